// File: doc/BRIEF.md
# I2C Command Target with Shared Response Buffer

This block is an I2C target that sits in front of a register-style command interface. A host addresses the block's command address for a write transfer. The first data byte is a sub-address that names a command. Bit 7 of that byte selects write (1) or read (0), and bits 6:0 hold the command code. The parameter bytes that follow are stored in one 512-byte buffer. When a complete write command is closed by a STOP, the command sink receives a one-cycle strobe carrying the code and the length, and it reads the parameters through a separate buffer read port.

A read command is a sub-address with bit 7 clear and no parameters. After its STOP, the sink gets the same strobe with a read flag set. The sink then writes the response into the same buffer through a staging port and marks it done. The host collects the response with a later transfer to a second, read-only I2C address. Because the buffer is shared, any other command accepted before that collection wipes the response.

SCL and SDA are sampled in the system clock domain through two-flop synchronisers. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SDA is driven open-drain through `sda_oe`.

Top module: `i2c_cmd_target`

## Requirements
- R1: Only the write-direction byte of the command address (default 7'h1A, address byte 0x34) and the read-direction byte of the read address (default 7'h1B, address byte 0x37) are ACKed. Every other address byte, including those two addresses with the opposite direction bit, leaves SDA released.
- R2: In the sub-address byte, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 are the code. Codes 0x01 to 0x3E need bits[3:0] parameter bytes. Code 0x3F needs 512 bytes. Codes 0x00 and 0x40 to 0x7F are unknown.
- R3: A sub-address with an unknown code is NACKed. It raises `err` for exactly one cycle and produces no command strobe.
- R4: Write parameter bytes are ACKed and stored from buffer index 0 upward in arrival order. A multi-byte parameter is sent least significant byte first, so its low byte lands at the lower index.
- R5: A data byte beyond a write command's count, or any data byte after a read sub-address, is NACKed and sets the sticky `ovf` flag. The counted bytes are still issued as a command.
- R6: A write command that has all its bytes at STOP pulses `cmd_valid` for one cycle with `cmd_rd`=0, the code and the count. A command with fewer bytes than its count at STOP produces no strobe.
- R7: A read sub-address closed by STOP pulses `cmd_valid` with `cmd_rd`=1 and `cmd_len` equal to the code's count. Accepting any known sub-address clears `rsp_valid`, and `stg_done` sets it.
- R8: A transfer to the read address returns buffer bytes from index 0 in order while `rsp_valid` is set and the index is below the response length. Otherwise it returns 0xFF.
- R9: A master NACK clears `rsp_valid` only when at least the response length has been sent. A shorter read leaves it set, and the next read starts again at index 0.
- R10: A response that is overwritten by another accepted command before collection reads back as 0xFF.
- R11: After reset, `sda_oe`, `cmd_valid`, `err`, `ovf` and `rsp_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_rd | output | 1 | Strobed command is a read |
| cmd_code | output | 7 | Strobed command code |
| cmd_len | output | 10 | Parameter count, or response length for a read |
| buf_raddr | input | 9 | Sink read address into the buffer |
| buf_rdata | output | 8 | Buffer byte at `buf_raddr` |
| stg_we | input | 1 | Response staging write enable |
| stg_addr | input | 9 | Response staging address |
| stg_data | input | 8 | Response staging data |
| stg_done | input | 1 | Response staged; sets `rsp_valid` |
| rsp_valid | output | 1 | A staged response is waiting |
| ovf | output | 1 | Sticky excess-byte flag |
| err | output | 1 | One-cycle unknown-code pulse |

## Verification
Directed transfers cover the boundaries:
- foreign and wrong-direction addresses, which separate address matching from direction checking;
- unknown codes at both ends of the code space;
- one byte too many and one byte too few, which separate the NACK-and-flag path from the no-strobe path;
- the 512-byte bulk command plus one, which exercises the buffer edge.

Read flows cover three further cases. A full read past the response length tells the 0xFF fill and the clearing NACK apart. A short read shows that an early NACK keeps the response and restarts at index 0. A write placed between staging and collection shows the shared buffer being lost. Random known and unknown codes with random parameter data then check the per-code count and the byte placement across the whole code range.

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] WR_ADDR = 7'h1A,
  parameter logic [6:0] RD_ADDR = 7'h1B,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          cmd_valid,
  output logic          cmd_rd,
  output logic [6:0]    cmd_code,
  output logic [LW-1:0] cmd_len,
  input  logic [AW-1:0] buf_raddr,
  output logic [7:0]    buf_rdata,
  input  logic          stg_we,
  input  logic [AW-1:0] stg_addr,
  input  logic [7:0]    stg_data,
  input  logic          stg_done,
  output logic          rsp_valid,
  output logic          ovf,
  output logic          err
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACKH, S_TX, S_MACK, S_MACKF, S_SKIP} st_t;

  function automatic logic [LW:0] cmd_info(input logic [6:0] c);
    logic [LW-1:0] n;
    n = (c == 7'h3F) ? LW'(DEPTH) : LW'(c[3:0]);
    return {(c != 7'h00) && !c[6], n};
  endfunction

  logic [2:0] scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sr, txsr;
  logic ack_ok, to_tx, in_addr, got_sub, pend, cur_wr;
  logic [6:0] cur_code;
  logic [LW-1:0] need, got, rd_idx, rsp_len;
  logic [7:0] mem [DEPTH];

  wire scl_s = scl_q[1], scl_p = scl_q[2];
  wire sda_s = sda_q[1], sda_p = sda_q[2];
  wire rise = scl_s & ~scl_p;
  wire fall = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c = scl_s & scl_p & ~sda_p & sda_s;

  wire [7:0] rxb = {sr[6:0], sda_s};
  wire rx_done = (st == S_RX) && rise && (cnt == 4'd7);
  wire [LW:0] info = cmd_info(rxb[6:0]);
  wire a_wr = rxb == {WR_ADDR, 1'b0};
  wire a_rd = rxb == {RD_ADDR, 1'b1};
  wire par_ok = pend && cur_wr && (got < need);
  wire pw_en = rx_done && !in_addr && got_sub && par_ok;
  wire [7:0] txbyte = (rsp_valid && rd_idx < rsp_len) ? mem[rd_idx[AW-1:0]] : 8'hFF;

  assign buf_rdata = mem[buf_raddr];

  always_ff @(posedge clk) begin
    if (pw_en) mem[got[AW-1:0]] <= rxb;
    else if (stg_we) mem[stg_addr] <= stg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111; sda_q <= 3'b111;
      st <= S_IDLE; cnt <= '0; sr <= '0; txsr <= '0;
      ack_ok <= 1'b0; to_tx <= 1'b0; in_addr <= 1'b0; got_sub <= 1'b0;
      pend <= 1'b0; cur_wr <= 1'b0; cur_code <= '0;
      need <= '0; got <= '0; rd_idx <= '0; rsp_len <= '0;
      rsp_valid <= 1'b0; ovf <= 1'b0; err <= 1'b0; sda_oe <= 1'b0;
      cmd_valid <= 1'b0; cmd_rd <= 1'b0; cmd_code <= '0; cmd_len <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      err <= 1'b0;
      cmd_valid <= 1'b0;
      if (stg_done) rsp_valid <= 1'b1;
      if (start_c) begin
        st <= S_RX; cnt <= '0; in_addr <= 1'b1; got_sub <= 1'b0;
        pend <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; pend <= 1'b0;
        if (pend && (!cur_wr || got == need)) begin
          cmd_valid <= 1'b1; cmd_rd <= !cur_wr;
          cmd_code <= cur_code; cmd_len <= need;
          if (!cur_wr) rsp_len <= need;
        end
      end else begin
        case (st)
          S_RX: if (rise) begin
            sr <= rxb;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              st <= S_ACKW; in_addr <= 1'b0; to_tx <= 1'b0;
              if (in_addr) begin
                ack_ok <= a_wr | a_rd; to_tx <= a_rd; rd_idx <= '0;
              end else if (!got_sub) begin
                got_sub <= 1'b1;
                ack_ok <= info[LW];
                if (info[LW]) begin
                  pend <= 1'b1; cur_wr <= rxb[7]; cur_code <= rxb[6:0];
                  need <= info[LW-1:0]; got <= '0; rsp_valid <= 1'b0;
                end else err <= 1'b1;
              end else begin
                ack_ok <= par_ok;
                if (par_ok) got <= got + 1'b1;
                else ovf <= 1'b1;
              end
            end
          end
          S_ACKW: if (fall) begin
            sda_oe <= ack_ok;
            st <= ack_ok ? S_ACKH : S_SKIP;
          end
          S_ACKH: if (fall) begin
            cnt <= '0;
            if (to_tx) begin
              txsr <= txbyte; sda_oe <= ~txbyte[7]; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
            end
          end
          S_TX: if (rise) cnt <= cnt + 4'd1;
                else if (fall) begin
                  if (cnt == 4'd8) begin
                    sda_oe <= 1'b0; st <= S_MACK;
                  end else begin
                    txsr <= {txsr[6:0], 1'b0}; sda_oe <= ~txsr[6];
                  end
                end
          S_MACK: if (rise) begin
            if (!sda_s) begin
              if (rd_idx < LW'(DEPTH)) rd_idx <= rd_idx + 1'b1;
              st <= S_MACKF;
            end else begin
              if ({1'b0, rd_idx} + 1'b1 >= {1'b0, rsp_len}) rsp_valid <= 1'b0;
              st <= S_SKIP;
            end
          end
          S_MACKF: if (fall) begin
            cnt <= '0; txsr <= txbyte; sda_oe <= ~txbyte[7]; st <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk #(
  parameter int DEPTH = 512,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          cmd_valid,
  input logic [LW-1:0] cmd_len,
  input logic          err,
  input logic          ovf,
  input logic          rsp_valid,
  input logic          stg_done
);
  p_sda_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len <= LW'(DEPTH));
  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_rsp_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(stg_done));
endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cmd_valid(cmd_valid), .cmd_len(cmd_len), .err(err), .ovf(ovf),
  .rsp_valid(rsp_valid), .stg_done(stg_done)
);

// File: tb/sim_i2c_cmd_target.sv
`timescale 1ns/1ps
module sim_i2c_cmd_target;
  localparam int Q = 5;
  localparam logic [6:0] WA = 7'h1A, RA = 7'h1B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, cmd_valid, cmd_rd, rsp_valid, ovf, err;
  logic [6:0] cmd_code;
  logic [9:0] cmd_len;
  logic [8:0] buf_raddr = '0, stg_addr = '0;
  logic [7:0] buf_rdata, stg_data = '0;
  logic stg_we = 1'b0, stg_done = 1'b0;
  wire sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_cmd_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_code(cmd_code), .cmd_len(cmd_len),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_data(stg_data), .stg_done(stg_done), .rsp_valid(rsp_valid), .ovf(ovf), .err(err)
  );

  int vec = 0, mis = 0, ncmd = 0, nerr = 0, lcode = 0, llen = 0, lrd = 0;
  logic [7:0] pdat [0:519];
  logic [7:0] rdat [0:15];
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin ncmd++; lcode = cmd_code; llen = cmd_len; lrd = cmd_rd; end
    if (err) nerr++;
  end

  function automatic bit exp_known(input int c);
    return c != 0 && c < 64;
  endfunction
  function automatic int exp_cnt(input int c);
    return (c == 63) ? 512 : (c & 15);
  endfunction
  function automatic logic [7:0] rsp_byte(input int c, input int i);
    return 8'(8'h30 + i) ^ 8'(c);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(posedge clk); #1; endtask

  task automatic i2c_start;
    m_sda = 1; m_scl = 1; wq; m_sda = 0; wq; m_scl = 0; wq;
  endtask
  task automatic i2c_stop;
    m_sda = 0; wq; m_scl = 1; wq; m_sda = 1; wq; wq;
  endtask
  task automatic wr_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq; m_scl = 1; wq; wq; m_scl = 0; wq;
    end
    m_sda = 1; wq; m_scl = 1; wq; acked = !sda_line; wq; m_scl = 0; wq;
  endtask
  task automatic rd_byte(input bit ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq; m_scl = 1; wq; b[i] = sda_line; wq; m_scl = 0;
    end
    wq; m_sda = ack ? 1'b0 : 1'b1; wq; m_scl = 1; wq; wq; m_scl = 0; wq; m_sda = 1;
  endtask

  task automatic do_write(input logic [7:0] sub, input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start;
    wr_byte({WA, 1'b0}, a); acks += a;
    wr_byte(sub, a); acks += a;
    for (int i = 0; i < n; i++) begin wr_byte(pdat[i], a); acks += a; end
    i2c_stop;
  endtask
  task automatic do_read(input int n, output bit aok);
    logic [7:0] b;
    i2c_start;
    wr_byte({RA, 1'b1}, aok);
    for (int i = 0; i < n; i++) begin rd_byte(i != n - 1, b); rdat[i] = b; end
    i2c_stop;
  endtask
  task automatic stage(input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 stg_we = 1; stg_addr = 9'(i); stg_data = rsp_byte(c, i);
    end
    @(posedge clk); #1 stg_we = 0; stg_done = 1;
    @(posedge clk); #1 stg_done = 0;
  endtask
  task automatic buf_at(input int i, output int v);
    buf_raddr = 9'(i); #1 v = buf_rdata;
  endtask
  task automatic addr_only(input logic [7:0] ab, output bit a);
    i2c_start; wr_byte(ab, a); i2c_stop;
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++; mis++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run;
    end
  end

  initial begin
    int acks, v, c0, n0;
    bit a;
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk); #1;
    // R11 reset state
    chk("R11 sda_oe", sda_oe, 0); chk("R11 cmd_valid", cmd_valid, 0);
    chk("R11 err", err, 0); chk("R11 ovf", ovf, 0); chk("R11 rsp_valid", rsp_valid, 0);

    // R1 address matching
    addr_only(8'h44, a); chk("R1 foreign addr nack", a, 0);
    addr_only({WA, 1'b1}, a); chk("R1 cmd addr read dir nack", a, 0);
    addr_only({RA, 1'b0}, a); chk("R1 read addr write dir nack", a, 0);
    addr_only({WA, 1'b0}, a); chk("R1 cmd addr ack", a, 1);

    // R4 R6 R2 write with a 16-bit parameter, LSB first
    pdat[0] = 8'hEF; pdat[1] = 8'hBE; pdat[2] = 8'h12;
    n0 = ncmd;
    do_write(8'h83, 3, acks);
    chk("R4 write acks", acks, 5);
    chk("R6 strobe count", ncmd - n0, 1);
    chk("R6 code", lcode, 3); chk("R2 len", llen, 3); chk("R6 rd flag", lrd, 0);
    buf_at(0, v); chk("R4 low byte idx0", v, 8'hEF);
    buf_at(1, v); chk("R4 high byte idx1", v, 8'hBE);
    buf_at(2, v); chk("R4 idx2", v, 8'h12);

    // R3 unknown codes
    n0 = ncmd; c0 = nerr;
    do_write(8'hC5, 2, acks); chk("R3 code 0x45 acks", acks, 1);
    do_write(8'h80, 0, acks); chk("R3 code 0x00 acks", acks, 1);
    chk("R3 err pulses", nerr - c0, 2); chk("R3 no strobe", ncmd - n0, 0);
    chk("R5 ovf untouched", ovf, 0);

    // R5 excess byte
    pdat[0] = 8'hA1; pdat[1] = 8'hA2; pdat[2] = 8'hA3; pdat[3] = 8'hA4;
    n0 = ncmd;
    do_write(8'h82, 4, acks);
    chk("R5 excess acks", acks, 4); chk("R5 ovf set", ovf, 1);
    chk("R5 still issued", ncmd - n0, 1); chk("R5 len", llen, 2);

    // R6 incomplete write
    n0 = ncmd;
    do_write(8'h84, 2, acks);
    chk("R6 short acks", acks, 4); chk("R6 short no strobe", ncmd - n0, 0);

    // R7 R8 R9 full read with fill
    n0 = ncmd;
    do_write(8'h06, 0, acks);
    chk("R7 read strobe", ncmd - n0, 1); chk("R7 rd flag", lrd, 1);
    chk("R7 code", lcode, 6); chk("R7 len", llen, 6); chk("R7 rsp cleared", rsp_valid, 0);
    stage(6, 6);
    chk("R7 rsp set", rsp_valid, 1);
    do_read(8, a);
    chk("R8 read addr ack", a, 1);
    for (int i = 0; i < 8; i++) chk("R8 read byte", rdat[i], i < 6 ? rsp_byte(6, i) : 8'hFF);
    chk("R9 rsp cleared after full", rsp_valid, 0);

    // R9 short read keeps response
    do_write(8'h04, 0, acks);
    stage(4, 4);
    do_read(2, a);
    chk("R9 short read byte0", rdat[0], rsp_byte(4, 0));
    chk("R9 short read keeps", rsp_valid, 1);
    do_read(4, a);
    for (int i = 0; i < 4; i++) chk("R9 reread from 0", rdat[i], rsp_byte(4, i));
    chk("R9 cleared", rsp_valid, 0);

    // R5 read sub-address followed by data
    do_write(8'h02, 1, acks);
    chk("R5 byte after read sub nack", acks, 2);

    // R10 overwrite by another command
    do_write(8'h03, 0, acks);
    stage(3, 3);
    pdat[0] = 8'h5A;
    do_write(8'h81, 1, acks);
    chk("R10 rsp lost", rsp_valid, 0);
    do_read(3, a);
    for (int i = 0; i < 3; i++) chk("R10 read fill", rdat[i], 8'hFF);

    // R2 R5 bulk command at buffer edge
    for (int i = 0; i < 513; i++) pdat[i] = 8'(i * 7 + 3);
    n0 = ncmd;
    do_write(8'hBF, 513, acks);
    chk("R5 bulk acks", acks, 514);
    chk("R2 bulk strobe", ncmd - n0, 1); chk("R2 bulk len", llen, 512);
    buf_at(0, v); chk("R4 bulk idx0", v, pdat[0]);
    buf_at(511, v); chk("R4 bulk idx511", v, pdat[511]);

    // random known and unknown codes
    for (int k = 0; k < 30; k++) begin
      int c, n;
      logic [7:0] sub;
      bit unk;
      unk = (k % 5) == 4;
      c = unk ? (($urandom_range(1, 0) == 1) ? 0 : int'($urandom_range(127, 64))) : int'($urandom_range(62, 1));
      sub = {1'b1, 7'(c)};
      n = exp_known(c) ? exp_cnt(c) : 2;
      for (int i = 0; i < n; i++) pdat[i] = 8'($urandom);
      n0 = ncmd; c0 = nerr;
      do_write(sub, n, acks);
      if (exp_known(c)) begin
        chk("R2 rand acks", acks, n + 2);
        chk("R6 rand strobe", ncmd - n0, 1);
        chk("R6 rand code", lcode, c); chk("R2 rand len", llen, n);
        for (int i = 0; i < n; i++) begin buf_at(i, v); chk("R4 rand data", v, pdat[i]); end
      end else begin
        chk("R3 rand acks", acks, 1);
        chk("R3 rand err", nerr - c0, 1); chk("R3 rand no strobe", ncmd - n0, 0);
      end
    end

    done = 1;
    finish_run;
  end
endmodule